// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer with Pipelined Read

This block takes one starting word address and turns it into the four word addresses of a burst. Those addresses read a small register array, and the read data leaves through a one-cycle output register. A start strobe captures the address, the order mode and beat index zero. Each later clock edge with the active-low advance input low moves to the next beat. The two low address bits follow either a wrap-around count or an XOR pattern. The upper bits stay fixed, so the burst never leaves its aligned four-word block.

A small finite-state machine controls the sequence. It has three states:
- `ST_IDLE`: no burst has started since reset.
- `ST_RUN`: beats 0 to 2 are presented.
- `ST_LAST`: the fourth beat is presented and held.

It has four transitions:
- `START` takes any state to `ST_RUN` when the strobe is high.
- `STEP` stays in `ST_RUN` on an advance while the beat index is below 2.
- `FINISH` goes from `ST_RUN` to `ST_LAST` on an advance at beat 2.
- `PARK` stays in `ST_LAST` or `ST_IDLE` when no strobe arrives.

A stall (advance high) keeps the state and the beat index. A strobe in mid-burst abandons the old burst at once. A plain synchronous write port fills the array.

Top module: `burst_seq_top`

## Requirements
- R1: After reset, `rd_valid_o` is 0 and `addr_o` is 0.
- R2: When `strobe_i` is 1 at a clock edge, `addr_o` equals the `addr_i` of that edge from that edge on, and the beat index is 0.
- R3: With linear order (mode bit 0 captured at the strobe), the low two bits of `addr_o` at beat n are (s + n) mod 4, where s is the low two bits of the start address.
- R4: With interleaved order (mode bit 1 captured at the strobe), the low two bits at beat n are s XOR n. `interleave_i` is sampled only on a strobe edge.
- R5: During a burst, `addr_o[AW-1:2]` stays equal to the start address's upper bits.
- R6: An edge with `adv_n_i` = 1 and no strobe leaves `addr_o` unchanged.
- R7: After the fourth beat (n = 3), `addr_o` holds until the next strobe, even with `adv_n_i` low.
- R8: A strobe during a burst loads the new address and mode at that edge and restarts at beat 0.
- R9: `rd_data_o` at a clock edge is the array word at the `addr_o` held before that edge. `rd_valid_o` is 1 exactly when a burst was active before that edge.
- R10: A clock edge with `wr_en_i` = 1 stores `wr_data_i` at `wr_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Start strobe; loads address and mode |
| adv_n_i | input | 1 | Active-low advance |
| interleave_i | input | 1 | Order select: 1 interleaved, 0 linear |
| addr_i | input | AW (6) | Burst start word address |
| wr_en_i | input | 1 | Array write enable |
| wr_addr_i | input | AW (6) | Array write address |
| wr_data_i | input | DW (16) | Array write data |
| addr_o | output | AW (6) | Current beat address |
| rd_data_o | output | DW (16) | Pipelined read data |
| rd_valid_o | output | 1 | Read data valid |

## Verification
A wrong beat index or a wrong captured start offset shows on `addr_o` in the same cycle as the faulty edge. One clock later it shows again as the wrong word on `rd_data_o`. Because every array word holds a distinct value, a misordered or skipped beat is exposed at once. A state machine that leaves `ST_LAST` by itself, or advances during a stall, changes `addr_o` on an edge where it must stay stable. A wrong valid pipeline shows on `rd_valid_o` one cycle after the first strobe.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_LAST = 2'd2
    } burst_state_t;

    // Low two address bits for beat n from start offset s
    function automatic logic [1:0] beat_low(input logic [1:0] s,
                                            input logic [1:0] n,
                                            input logic       interleaved);
        if (interleaved)
            return s ^ n;
        else
            return s + n;
    endfunction

endpackage

// File: rtl/burst_counter.sv
module burst_counter
    import burst_seq_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_i,
    input  logic          adv_n_i,
    input  logic          interleave_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] addr_o,
    output logic          active_o
);

    localparam int LAST_STEP = 2;

    burst_state_t  state_q, state_d;
    logic [1:0]    beat_q, beat_d;
    logic [AW-1:0] start_q, start_d;
    logic          mode_q, mode_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= 2'd0;
            start_q <= '0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            start_q <= start_d;
            mode_q  <= mode_d;
        end
    end

    // Next state and counter
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        start_d = start_q;
        mode_d  = mode_q;
        if (strobe_i) begin
            state_d = ST_RUN;
            beat_d  = 2'd0;
            start_d = addr_i;
            mode_d  = interleave_i;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RUN: begin
                    if (!adv_n_i) begin
                        beat_d = beat_q + 2'd1;
                        if (beat_q == 2'(LAST_STEP))
                            state_d = ST_LAST;
                    end
                end
                ST_LAST: state_d = ST_LAST;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        addr_o   = {start_q[AW-1:2], beat_low(start_q[1:0], beat_q, mode_q)};
        active_o = (state_q != ST_IDLE);
    end

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> addr_o == $past(addr_i)); // R2

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_i && active_o) |=> addr_o[AW-1:2] == $past(addr_o[AW-1:2])); // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_i && adv_n_i) |=> $stable(addr_o)); // R6

    AST_LAST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LAST && !strobe_i) |=> $stable(addr_o)); // R7

    AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !strobe_i && !adv_n_i) |=> addr_o[1:0] != $past(addr_o[1:0])); // R3

endmodule

// File: rtl/burst_array.sv
module burst_array #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    input  logic          active_i,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_valid_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i)
            mem[wr_addr_i] <= wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_data_o  <= mem[rd_addr_i];
            rd_valid_o <= active_i;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |=> rd_valid_o); // R9

    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !rd_valid_o); // R9

endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_i,
    input  logic          adv_n_i,
    input  logic          interleave_i,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_valid_o
);

    logic active;

    burst_counter #(.AW(AW)) u_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_i     (strobe_i),
        .adv_n_i      (adv_n_i),
        .interleave_i (interleave_i),
        .addr_i       (addr_i),
        .addr_o       (addr_o),
        .active_o     (active)
    );

    burst_array #(.AW(AW), .DW(DW)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .rd_addr_i  (addr_o),
        .active_i   (active),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o)
    );

endmodule

// File: tb/burst_seq_top_test.sv
module burst_seq_top_test;

    localparam int AW = 6;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strobe_i = 1'b0;
    logic          adv_n_i = 1'b1;
    logic          interleave_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          wr_en_i = 1'b0;
    logic [AW-1:0] wr_addr_i = '0;
    logic [DW-1:0] wr_data_i = '0;
    logic [AW-1:0] addr_o;
    logic [DW-1:0] rd_data_o;
    logic          rd_valid_o;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // reference model state
    logic [DW-1:0] mm [1 << AW];
    bit            m_act = 0;
    logic [AW-1:0] m_start = '0;
    bit            m_il = 0;
    int            m_beat = 0;

    always #5 clk = ~clk;

    burst_seq_top #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .adv_n_i(adv_n_i),
        .interleave_i(interleave_i), .addr_i(addr_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .addr_o(addr_o),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
    );

    function automatic logic [AW-1:0] model_addr();
        logic [1:0] s, n, lo;
        s  = m_start[1:0];
        n  = 2'(m_beat);
        lo = m_il ? (s ^ n) : 2'(s + n);
        return {m_start[AW-1:2], lo};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, check at next negedge
    task automatic cyc(input bit strb, input logic [AW-1:0] a, input bit il,
                       input bit advn, input string tag);
        logic [DW-1:0] exp_d;
        bit            exp_v;
        strobe_i = strb; addr_i = a; interleave_i = il; adv_n_i = advn;
        @(posedge clk);
        exp_v = m_act;
        exp_d = mm[model_addr()];
        if (strb) begin
            m_act = 1; m_start = a; m_il = il; m_beat = 0;
        end else if (m_act && !advn && m_beat < 3) begin
            m_beat++;
        end
        @(negedge clk);
        check(rd_valid_o == exp_v, {tag, " R9 valid"}, int'(rd_valid_o), int'(exp_v));
        if (exp_v)
            check(rd_data_o == exp_d, {tag, " R9/R10 data"}, int'(rd_data_o), int'(exp_d));
        if (m_act)
            check(addr_o == model_addr(), {tag, " addr"}, int'(addr_o), int'(model_addr()));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++)
            mm[i] = 16'(i * 16'h0131) ^ 16'h5A00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rd_valid_o == 1'b0, "R1 valid", int'(rd_valid_o), 0);
        check(addr_o == '0, "R1 addr", int'(addr_o), 0);

        // R10 preload through write port
        for (int i = 0; i < (1 << AW); i++) begin
            wr_en_i = 1'b1; wr_addr_i = AW'(i); wr_data_i = mm[i];
            @(negedge clk);
        end
        wr_en_i = 1'b0;

        // R2 R3 R4 R5 R7: all offsets, both orders, several blocks
        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 4; s++) begin
                for (int b = 0; b < 16; b += 5) begin
                    cyc(1, AW'(b * 4 + s), md[0], 1, "R2 load");
                    for (int k = 0; k < 3; k++)
                        cyc(0, '0, ~md[0], 0, md ? "R4 interleaved" : "R3 linear");
                    cyc(0, '0, 0, 0, "R5 block");
                    cyc(0, '0, 0, 0, "R7 hold after last");
                    cyc(0, '0, 0, 0, "R7 hold after last");
                end
            end
        end

        // R6 stalls in mid-burst
        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 4; s++) begin
                cyc(1, AW'(36 + s), md[0], 1, "R2 load");
                cyc(0, '0, 0, 0, "R6 step");
                cyc(0, '0, 0, 1, "R6 stall");
                cyc(0, '0, 0, 1, "R6 stall");
                cyc(0, '0, 0, 0, "R6 step");
                cyc(0, '0, 0, 1, "R6 stall");
                cyc(0, '0, 0, 0, "R6 step");
                cyc(0, '0, 0, 0, "R6 step");
            end
        end

        // R8 abort in mid-burst and from the last beat
        cyc(1, AW'(13), 0, 1, "R8 first");
        cyc(0, '0, 0, 0, "R8 step");
        cyc(1, AW'(50), 1, 0, "R8 abort");
        cyc(0, '0, 0, 0, "R8 new burst");
        cyc(0, '0, 0, 0, "R8 new burst");
        cyc(0, '0, 0, 0, "R8 new burst");
        cyc(0, '0, 0, 0, "R8 new burst");
        cyc(1, AW'(7), 0, 0, "R8 restart from last");
        cyc(0, '0, 0, 0, "R8 new burst");
        cyc(0, '0, 0, 0, "R8 new burst");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule